// File: doc/BRIEF.md
# Dual-Pending Interrupt Controller

This controller gathers 32 level-sensitive interrupt sources and presents them to a processor core on two request lines: a fast request and a normal request. Every source that asserts is latched into a raw pending register, whether or not it is enabled. Enabled sources routed to the normal line compete in a fixed-priority arbiter. The single winner is parked in a one-hot service register, and the normal request stays high while that register is non-zero. Enabled sources routed to the fast line skip the service register and drive the fast request directly.

Software reaches the block through a small synchronous register bus. Writes take effect at the next clock edge, and reads return data in the same cycle. The register offsets are: 0 raw pending, 1 enable mask, 2 line select, 3 service register, 4 winner index. A service routine first acknowledges the raw pending bit and then the service bit, in each case by writing 1 to that bit. Once the service register is empty, the next enabled normal-line source is loaded into it.

Top module: `irq_dual_pend_ctrl`

## Requirements
- R1: After reset, the mask register (offset 1) reads all ones, the line select register (offset 2) reads zero, both pending registers (offsets 0 and 3) read zero, and both request outputs are low.
- R2: A source that is high at a clock edge sets its bit in the raw pending register (offset 0) at that edge, whatever its mask bit. The bit stays set after the source falls.
- R3: A source whose mask bit is 1 never enters the service register (offset 3) and never raises either request output, even while its raw pending bit is set.
- R4: Writing offset 0 clears each raw pending bit whose written data bit is 1 and leaves the others unchanged. If a source is high in the same cycle as the clear of its bit, the bit stays set.
- R5: The service register holds at most one set bit. When it is zero, the next edge loads the lowest-numbered source that is pending, unmasked and has line select 0. While it is non-zero, it does not change except through a clear.
- R6: Writing offset 3 clears each service bit whose written data bit is 1. A written 0 leaves the bit unchanged.
- R7: A source with line select bit 1 never enters the service register. The fast request output is high whenever any unmasked raw pending bit with line select 1 is set.
- R8: The normal request output is high exactly while the service register is non-zero.
- R9: Reading offset 4 returns the index of the set service bit, zero-extended.
- R10: The mask and line select registers read back the last value written to offsets 1 and 2.
- R11: If software clears the raw pending bit and then the service bit of a source that has gone low, that source is not serviced again. If the source is still high, its raw bit stays set and it is serviced again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| srcReq | input | NUM_SRC | Level interrupt sources, already synchronous to clk |
| busAddr | input | ADDR_W | Register offset |
| busWrEn | input | 1 | Write strobe for busAddr |
| busWrData | input | NUM_SRC | Write data |
| busRdData | output | NUM_SRC | Read data for busAddr, combinational |
| fiqReq | output | 1 | Fast interrupt request |
| irqReq | output | 1 | Normal interrupt request |

## Verification
The assertions assume that `srcReq` is already synchronous to `clk`. They also assume that the bus presents at most one write per cycle and that the write is decoded from `busAddr` in that same cycle. The bench changes sources and bus signals only on falling edges and samples on the falling edge that follows. Every stimulus therefore lands on one known rising edge, and the one-cycle gap between a raw pending bit setting and the service register loading is always counted. Each acknowledge sequence holds the source either low or high through both clears, so that each outcome of R11 is exercised without ambiguity.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [2:0] {
    SEL_SRCPEND = 3'd0,
    SEL_MASK    = 3'd1,
    SEL_MODE    = 3'd2,
    SEL_INTPEND = 3'd3,
    SEL_OFFSET  = 3'd4,
    SEL_NONE    = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    clrSrcPend;
    logic    ldMask;
    logic    ldMode;
    logic    clrIntPend;
    regSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] req,
  output logic [WIDTH-1:0] grant
);
  logic [WIDTH:0] anyBelow;

  assign anyBelow[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pick
    assign grant[i]      = req[i] & ~anyBelow[i];
    assign anyBelow[i+1] = anyBelow[i] | req[i];
  end
endmodule

// File: rtl/irqc_onehot_index.sv
module irqc_onehot_index #(
  parameter int WIDTH = 32,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] oneHot,
  output logic [IDX_W-1:0] index
);
  always_comb begin
    index = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (oneHot[i]) index = index | IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobe_t       strobe
);
  always_comb begin
    strobe       = '0;
    strobe.rdSel = SEL_NONE;
    case (int'(busAddr))
      0: begin
        strobe.rdSel      = SEL_SRCPEND;
        strobe.clrSrcPend = busWrEn;
      end
      1: begin
        strobe.rdSel  = SEL_MASK;
        strobe.ldMask = busWrEn;
      end
      2: begin
        strobe.rdSel  = SEL_MODE;
        strobe.ldMode = busWrEn;
      end
      3: begin
        strobe.rdSel      = SEL_INTPEND;
        strobe.clrIntPend = busWrEn;
      end
      4: strobe.rdSel = SEL_OFFSET;
      default: strobe.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  ctrlStrobe_t        strobe,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] rdData,
  output logic [NUM_SRC-1:0] srcPendQ,
  output logic [NUM_SRC-1:0] intPendQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] modeQ,
  output logic               fiqReq,
  output logic               irqReq
);
  logic [NUM_SRC-1:0] srcClr;
  logic [NUM_SRC-1:0] irqCand;
  logic [NUM_SRC-1:0] irqGrant;
  logic [IDX_W-1:0]   winIdx;

  assign srcClr  = strobe.clrSrcPend ? wrData : '0;
  assign irqCand = srcPendQ & ~maskQ & ~modeQ;

  irqc_prio_pick #(.WIDTH(NUM_SRC)) u_pick (
    .req   (irqCand),
    .grant (irqGrant)
  );

  irqc_onehot_index #(.WIDTH(NUM_SRC)) u_idx (
    .oneHot (intPendQ),
    .index  (winIdx)
  );

  // raw pending: a new request outranks a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcPendQ <= '0;
    else       srcPendQ <= (srcPendQ & ~srcClr) | srcReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  intPendQ <= '0;
    else if (intPendQ == '0)    intPendQ <= irqGrant;
    else if (strobe.clrIntPend) intPendQ <= intPendQ & ~wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
      modeQ <= '0;
    end else begin
      if (strobe.ldMask) maskQ <= wrData;
      if (strobe.ldMode) modeQ <= wrData;
    end
  end

  assign fiqReq = |(srcPendQ & ~maskQ & modeQ);
  assign irqReq = |intPendQ;

  always_comb begin
    case (strobe.rdSel)
      SEL_SRCPEND: rdData = srcPendQ;
      SEL_MASK:    rdData = maskQ;
      SEL_MODE:    rdData = modeQ;
      SEL_INTPEND: rdData = intPendQ;
      SEL_OFFSET:  rdData = NUM_SRC'(winIdx);
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_dual_pend_ctrl.sv
module irq_dual_pend_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [NUM_SRC-1:0] busWrData,
  output logic [NUM_SRC-1:0] busRdData,
  output logic               fiqReq,
  output logic               irqReq
);
  ctrlStrobe_t        strobe;
  logic [NUM_SRC-1:0] srcPendQ;
  logic [NUM_SRC-1:0] intPendQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] modeQ;

  irqc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  irqc_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcReq   (srcReq),
    .strobe   (strobe),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .srcPendQ (srcPendQ),
    .intPendQ (intPendQ),
    .maskQ    (maskQ),
    .modeQ    (modeQ),
    .fiqReq   (fiqReq),
    .irqReq   (irqReq)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcReq,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWrEn,
  input logic [NUM_SRC-1:0] busWrData,
  input logic [NUM_SRC-1:0] srcPendQ,
  input logic [NUM_SRC-1:0] intPendQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [NUM_SRC-1:0] modeQ
);
  logic wrSrc;
  logic wrInt;
  assign wrSrc = busWrEn && (busAddr == ADDR_W'(0));
  assign wrInt = busWrEn && (busAddr == ADDR_W'(3));

  a_r2_src_latches: assert property (@(posedge clk) disable iff (!rstN)
    (|srcReq) |=> ((srcPendQ & $past(srcReq)) == $past(srcReq)));

  a_r4_clear_quiet_src: assert property (@(posedge clk) disable iff (!rstN)
    wrSrc |=> ((srcPendQ & $past(busWrData) & ~$past(srcReq)) == '0));

  a_r5_single_winner: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(intPendQ));

  a_r5_hold_until_clear: assert property (@(posedge clk) disable iff (!rstN)
    ((intPendQ != '0) && !wrInt) |=> $stable(intPendQ));

  // R3 and R7: a freshly loaded winner was enabled and on the normal line
  a_r3_load_eligible: assert property (@(posedge clk) disable iff (!rstN)
    ((intPendQ != '0) && ($past(intPendQ) == '0)) |->
      ((intPendQ & ($past(maskQ) | $past(modeQ))) == '0));
endmodule

bind irq_dual_pend_ctrl irqc_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .srcReq    (srcReq),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .srcPendQ  (srcPendQ),
  .intPendQ  (intPendQ),
  .maskQ     (maskQ),
  .modeQ     (modeQ)
);

// File: tb/irq_dual_pend_ctrl_tb.sv
module irq_dual_pend_ctrl_tb;
  localparam int NS = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] srcReq = '0;
  logic [AW-1:0] busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [NS-1:0] busWrData = '0;
  logic [NS-1:0] busRdData;
  logic          fiqReq;
  logic          irqReq;

  int   checkCnt = 0;
  int   failCnt  = 0;
  logic chkStrobe = 1'b0;
  logic finished = 1'b0;

  logic [NS-1:0] expQ[$];
  int            kindQ[$];
  string         tagQ[$];

  always #5 clk = ~clk;

  irq_dual_pend_ctrl #(.NUM_SRC(NS), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .fiqReq(fiqReq), .irqReq(irqReq)
  );

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busWrEn = 1'b0; chkStrobe = 1'b0;
    end
  endtask

  task automatic regWrite(input logic [AW-1:0] a, input logic [NS-1:0] d);
    @(negedge clk);
    chkStrobe = 1'b0; busAddr = a; busWrData = d; busWrEn = 1'b1;
  endtask

  task automatic expectReg(input logic [AW-1:0] a, input logic [NS-1:0] e, input string tag);
    @(negedge clk);
    busWrEn = 1'b0; busAddr = a;
    expQ.push_back(e); kindQ.push_back(0); tagQ.push_back(tag);
    chkStrobe = 1'b1;
  endtask

  // expected value is {fiqReq, irqReq}
  task automatic expectPins(input logic [1:0] e, input string tag);
    @(negedge clk);
    busWrEn = 1'b0;
    expQ.push_back(NS'(e)); kindQ.push_back(1); tagQ.push_back(tag);
    chkStrobe = 1'b1;
  endtask

  // monitor: pops one expected item per strobed cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (chkStrobe && expQ.size() > 0) begin
        logic [NS-1:0] e;
        logic [NS-1:0] got;
        int            k;
        string         t;
        e = expQ.pop_front(); k = kindQ.pop_front(); t = tagQ.pop_front();
        got = (k == 0) ? busRdData : NS'({fiqReq, irqReq});
        checkCnt++;
        if (got !== e) begin
          failCnt++;
          $display("FAIL %s: got %h expected %h", t, got, e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expectReg(1, '1, "R1 mask");
    expectReg(2, '0, "R1 mode");
    expectReg(0, '0, "R1 srcPend");
    expectReg(3, '0, "R1 intPend");
    expectPins(2'b00, "R1 pins");

    // R2/R3 masked source still latches
    srcReq = NS'(1) << 5;
    idle(1);
    expectReg(0, 32'h20, "R2 set while masked");
    expectReg(3, '0, "R3 masked not arbitrated");
    srcReq = '0;
    expectPins(2'b00, "R3 masked no request");
    idle(1);
    expectReg(0, 32'h20, "R2 sticky");
    regWrite(0, 32'h20);
    expectReg(0, '0, "R4 write one clears");

    // R4 zero write keeps
    srcReq = NS'(1) << 3;
    idle(1);
    srcReq = '0;
    regWrite(0, '0);
    expectReg(0, 32'h8, "R4 write zero keeps");
    regWrite(0, 32'h8);
    expectReg(0, '0, "R4 clear bit3");

    // R4 set beats clear
    srcReq = NS'(1) << 7;
    idle(1);
    regWrite(0, 32'h80);
    expectReg(0, 32'h80, "R4 set wins");
    srcReq = '0;
    regWrite(0, 32'h80);
    expectReg(0, '0, "R4 clear bit7");

    // enable 4, 9, 12, 20
    regWrite(1, ~NS'(32'h0010_1210));
    expectReg(1, ~NS'(32'h0010_1210), "R10 mask readback");

    // R5 arbitration
    srcReq = NS'(32'h1200);
    idle(1);
    expectReg(3, 32'h200, "R5 lowest wins");
    expectReg(4, 32'd9, "R9 offset 9");
    expectPins(2'b01, "R8 irq high");
    expectReg(0, 32'h1200, "R2 both latched");
    srcReq = NS'(1) << 4;
    idle(1);
    srcReq = '0;
    expectReg(3, 32'h200, "R5 no preempt");

    // R11 clear order, source low
    regWrite(0, 32'h200);
    regWrite(3, 32'h200);
    expectPins(2'b00, "R8 irq low when empty");
    expectReg(3, 32'h10, "R5 next winner 4");
    expectReg(4, 32'd4, "R9 offset 4");
    regWrite(0, 32'h10);
    regWrite(3, 32'h10);
    idle(1);
    expectReg(3, 32'h1000, "R5 next winner 12");
    regWrite(0, 32'h1000);
    regWrite(3, 32'h1000);
    idle(2);
    expectReg(3, '0, "R11 not serviced again");
    expectReg(0, '0, "R11 raw empty");

    // R11 source still high
    srcReq = NS'(1) << 9;
    idle(1);
    expectReg(3, 32'h200, "R11 first service");
    regWrite(0, 32'h200);
    regWrite(3, 32'h200);
    idle(1);
    expectReg(3, 32'h200, "R11 reserviced while high");
    srcReq = '0;
    regWrite(0, 32'h200);
    regWrite(3, 32'h200);
    idle(1);
    expectReg(3, '0, "R11 done");

    // R6 zero write keeps
    srcReq = NS'(1) << 12;
    idle(1);
    srcReq = '0;
    regWrite(3, '0);
    expectReg(3, 32'h1000, "R6 write zero keeps");
    regWrite(0, 32'h1000);
    regWrite(3, 32'h1000);
    idle(1);
    expectReg(3, '0, "R6 write one clears");

    // R7 fast routing
    regWrite(2, NS'(32'h0010_0000));
    expectReg(2, 32'h0010_0000, "R10 mode readback");
    srcReq = NS'(1) << 20;
    idle(1);
    expectPins(2'b10, "R7 fiq only");
    expectReg(3, '0, "R7 bypasses intPend");
    srcReq = '0;
    regWrite(0, 32'h0010_0000);
    expectPins(2'b00, "R7 fiq drops after clear");

    // R3 masked fast source
    regWrite(2, NS'(32'h0030_0000));
    srcReq = NS'(1) << 21;
    idle(1);
    srcReq = '0;
    expectPins(2'b00, "R3 masked fast silent");
    expectReg(0, 32'h0020_0000, "R2 masked fast latched");
    regWrite(0, 32'h0020_0000);

    // both lines together
    srcReq = NS'(32'h0010_0010);
    idle(1);
    srcReq = '0;
    expectPins(2'b11, "R7 R8 both lines");
    expectReg(3, 32'h10, "R5 normal winner with fast pending");

    idle(2);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checkCnt, failCnt);
    $finish;
  end
endmodule